// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Serial Front End

This block is the digital side of a four-channel digital-to-analog converter. A host writes 24-bit words over a framed three-wire serial link: a frame-select line (active low), a serial clock and a data line. The block oversamples all three with its own system clock and shifts a bit in on each falling edge of the serial clock. When the frame closes with exactly 24 bits, it decodes the word and writes the 16-bit payload into the input register of the addressed channel.

Each channel also has an output register that drives the converter code. A load-strobe input sets when input registers move to output registers. If the strobe is held low, the written channel's output follows at the end of the frame. If the strobe is held high, only the input register changes, and a later falling edge of the strobe copies all four input registers at once. A falling edge on the clear input zeroes every data register. While the clamp input is low, all four codes are forced to the zero-volt code and the stored values are kept. A serial data output repeats the input stream 24 bits late, so several devices can share one link in a chain.

The receiver is a four-state machine. `ST_IDLE` waits for the frame-select line to fall (transition *open*). `ST_SHIFT` takes one bit on each serial-clock fall. When the frame-select line rises it goes to `ST_COMMIT` if the bit count is exactly 24 (transition *close-good*), and to `ST_DISCARD` for any other count (transition *close-bad*). Both of those states return to `ST_IDLE` after one cycle (transition *retire*). Only `ST_COMMIT` may issue a register write.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is taken only while `sync_n` is low, one bit per `sclk` falling edge, most significant bit first. Bit 23 is read/write (0 = write), bits 22:20 are the register select, bits 19:18 are the channel (0 to 3), bits 17:16 are reserved and bits 15:0 are the data. A frame is a data write when bit 23 is 0, the select is 3'b010 and the reserved bits are 00.
- R2: A frame that closes after any number of `sclk` falling edges other than 24 is dropped and changes no register.
- R3: A 24-bit frame that is not a data write (read bit set, another select value, or non-zero reserved bits) changes no register.
- R4: While `ldac_n` is low, a data write also updates the addressed channel's output code when `sync_n` rises.
- R5: While `ldac_n` is high, a data write loads only the input register and the output codes stay unchanged.
- R6: A falling edge on `ldac_n` copies all four input registers into the output registers in the same cycle.
- R7: A falling edge on `clr_n` sets all input and output registers to 0x0000. Holding `clr_n` low has no further effect, so writes made during that time are accepted.
- R8: While `rstin_n` is low, every 16-bit field of `dac_codes` shows the zero-volt code (0x8000 when `twos_comp` = 0, 0x0000 when `twos_comp` = 1) and `clamp_active` is 1. The stored values come back when `rstin_n` returns high.
- R9: `sdo` changes only on an `sclk` rising edge inside a frame and presents each bit 24 `sclk` periods after it entered on `sdin`.
- R10: After reset all codes are 0x0000, `clamp_active` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock; data is captured on its falling edge |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Load strobe: low level gives automatic update, falling edge copies all channels |
| clr_n | input | 1 | Clear; a falling edge zeroes the data registers |
| rstin_n | input | 1 | Clamp request, active low |
| twos_comp | input | 1 | Static coding select: 1 = two's complement, 0 = offset binary |
| sdo | output | 1 | Serial data out for chaining |
| dac_codes | output | 64 | Converter codes; channel n is in bits 16n+15:16n |
| clamp_active | output | 1 | High while outputs are clamped |

## Verification
Single data writes with the strobe held low go to different channels with distinct values, which shows that channel addressing and data placement are correct. Frames of 23 and 25 bits, a read frame and a frame with a wrong select show that only a well-formed 24-bit write commits anything. Writes made with the strobe held high and followed by one strobe fall separate input registers from output registers. The clear, with a write while it is still held low, shows that the clear acts on an edge and reaches the input registers. The clamp is tried in both coding modes and then released to show the stored codes return. A read frame followed by a second frame, with `sdo` captured before each falling edge, shows the 24-bit chain delay.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    localparam int DATA_W  = 16;
    localparam int CH_N    = 4;
    localparam int CH_AW   = 2;
    localparam int SEL_W   = 3;
    localparam int RSV_W   = 2;
    localparam int FRAME_W = 1 + SEL_W + CH_AW + RSV_W + DATA_W;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT,
        ST_DISCARD
    } rx_state_t;
endpackage

// File: rtl/dac_sync_bit.sv
module dac_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_fe_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int DW = DATA_W,
    parameter int AW = CH_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_lvl,
    input  logic          sync_fall,
    input  logic          sync_rise,
    input  logic          sclk_fall,
    input  logic          sclk_rise,
    input  logic          sdin_lvl,
    output logic          wr_en,
    output logic [AW-1:0] wr_ch,
    output logic [DW-1:0] wr_data,
    output logic          sdo
);
    localparam int CNT_W = $clog2(FW + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);

    rx_state_t        state_q, state_d;
    logic [FW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;
    logic             sdo_q;
    logic             is_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sync_fall) state_d = ST_SHIFT;
            ST_SHIFT:   if (sync_rise) state_d = (cnt == CNT_FULL) ? ST_COMMIT : ST_DISCARD;
            ST_COMMIT:  state_d = ST_IDLE;
            ST_DISCARD: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (state_q == ST_IDLE && sync_fall) begin
            cnt <= '0;
        end else if (state_q == ST_SHIFT && sclk_fall && !sync_lvl) begin
            shreg <= {shreg[FW-2:0], sdin_lvl};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               sdo_q <= 1'b0;
        else if (state_q == ST_SHIFT && sclk_rise) sdo_q <= shreg[FW-1];
    end

    assign is_write = !shreg[FW-1]
                   && (shreg[FW-2 -: SEL_W] == SEL_DATA)
                   && (shreg[DW +: RSV_W] == '0);

    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    wr_en = 1'b0;
            ST_SHIFT:   wr_en = 1'b0;
            ST_COMMIT:  wr_en = is_write;
            ST_DISCARD: wr_en = 1'b0;
        endcase
    end

    assign wr_ch   = shreg[DW+RSV_W +: AW];
    assign wr_data = shreg[DW-1:0];
    assign sdo     = sdo_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_fe_pkg::*;
#(
    parameter int NCH = CH_N,
    parameter int DW  = DATA_W,
    parameter int AW  = CH_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_ch,
    input  logic [DW-1:0]     wr_data,
    input  logic              ldac_lvl,
    input  logic              ldac_fall,
    input  logic              clr_fall,
    output logic [NCH*DW-1:0] in_flat,
    output logic [NCH*DW-1:0] out_flat
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [DW-1:0] in_q, out_q;
            logic          hit;
            assign hit = wr_en && (wr_ch == AW'(c));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    in_q <= '0;
                else if (clr_fall) in_q <= '0;
                else if (hit)  in_q <= wr_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 out_q <= '0;
                else if (clr_fall)          out_q <= '0;
                else if (hit && !ldac_lvl)  out_q <= wr_data;
                else if (ldac_fall)         out_q <= in_q;
            end

            assign in_flat[c*DW +: DW]  = in_q;
            assign out_flat[c*DW +: DW] = out_q;
        end
    endgenerate
endmodule

// File: rtl/dac_clamp_mux.sv
module dac_clamp_mux
    import dac_fe_pkg::*;
#(
    parameter int NCH = CH_N,
    parameter int DW  = DATA_W
) (
    input  logic [NCH*DW-1:0] out_flat,
    input  logic              clamp,
    input  logic              twos_comp,
    output logic [NCH*DW-1:0] codes
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
    logic [DW-1:0] zero_code;

    assign zero_code = twos_comp ? '0 : MID;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign codes[c*DW +: DW] = clamp ? zero_code : out_flat[c*DW +: DW];
        end
    endgenerate
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dac_fe_pkg::*;
#(
    parameter int NCH     = CH_N,
    parameter int DW      = DATA_W,
    parameter int AW      = CH_AW,
    parameter int STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              rstin_n,
    input  logic              twos_comp,
    output logic              sdo,
    output logic [NCH*DW-1:0] dac_codes,
    output logic              clamp_active
);
    localparam int NIN = 6;
    localparam int NEDGE = 4;
    // index map: 0 sync, 1 sclk, 2 ldac, 3 clr, 4 sdin, 5 rstin
    localparam logic [NIN-1:0] RST_VALS = 6'b101101;

    logic [NIN-1:0]   raw_in, lvl;
    logic [NEDGE-1:0] prv;
    logic             sync_lvl, sync_fall, sync_rise;
    logic             sclk_fall, sclk_rise;
    logic             ldac_lvl, ldac_fall, clr_fall;
    logic             wr_en;
    logic [AW-1:0]    wr_ch;
    logic [DW-1:0]    wr_data;
    logic [NCH*DW-1:0] in_flat, out_flat;

    assign raw_in = {rstin_n, sdin, clr_n, ldac_n, sclk, sync_n};

    generate
        for (genvar i = 0; i < NIN; i++) begin : g_sync
            dac_sync_bit #(.STAGES(STAGES), .RST_VAL(RST_VALS[i])) i_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_in[i]),
                .lvl   (lvl[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= RST_VALS[NEDGE-1:0];
        else        prv <= lvl[NEDGE-1:0];
    end

    assign sync_lvl  = lvl[0];
    assign sync_fall = prv[0] & ~lvl[0];
    assign sync_rise = ~prv[0] & lvl[0];
    assign sclk_fall = prv[1] & ~lvl[1];
    assign sclk_rise = ~prv[1] & lvl[1];
    assign ldac_lvl  = lvl[2];
    assign ldac_fall = prv[2] & ~lvl[2];
    assign clr_fall  = prv[3] & ~lvl[3];

    dac_frame_rx #(.FW(FRAME_W), .DW(DW), .AW(AW)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_lvl  (sync_lvl),
        .sync_fall (sync_fall),
        .sync_rise (sync_rise),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .sdin_lvl  (lvl[4]),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .sdo       (sdo)
    );

    dac_reg_bank #(.NCH(NCH), .DW(DW), .AW(AW)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .ldac_lvl  (ldac_lvl),
        .ldac_fall (ldac_fall),
        .clr_fall  (clr_fall),
        .in_flat   (in_flat),
        .out_flat  (out_flat)
    );

    assign clamp_active = ~lvl[5];

    dac_clamp_mux #(.NCH(NCH), .DW(DW)) i_mux (
        .out_flat  (out_flat),
        .clamp     (clamp_active),
        .twos_comp (twos_comp),
        .codes     (dac_codes)
    );
endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_fall,
    input logic              ldac_lvl,
    input logic              ldac_fall,
    input logic              wr_en,
    input logic              sclk_rise,
    input logic              sdo,
    input logic              twos_comp,
    input logic              clamp_active,
    input logic [NCH*DW-1:0] in_flat,
    input logic [NCH*DW-1:0] out_flat,
    input logic [NCH*DW-1:0] dac_codes
);
    logic [DW-1:0] zc;
    assign zc = twos_comp ? '0 : {1'b1, {(DW-1){1'b0}}};

    AST_HOLD_WHILE_LDAC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_lvl && !clr_fall) |=> $stable(out_flat)); // R5

    AST_LDAC_FALL_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_fall && !clr_fall && !wr_en) |=> (out_flat == $past(in_flat))); // R6

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> (out_flat == '0 && in_flat == '0)); // R7

    AST_CLAMP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_active |-> (dac_codes == {NCH{zc}})); // R8

    AST_SDO_ON_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(sdo)); // R9
endmodule

bind dac_serial_front dac_fe_checker #(.NCH(NCH), .DW(DW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_fall     (clr_fall),
    .ldac_lvl     (ldac_lvl),
    .ldac_fall    (ldac_fall),
    .wr_en        (wr_en),
    .sclk_rise    (sclk_rise),
    .sdo          (sdo),
    .twos_comp    (twos_comp),
    .clamp_active (clamp_active),
    .in_flat      (in_flat),
    .out_flat     (out_flat),
    .dac_codes    (dac_codes)
);

// File: tb/test_dac_serial_front.sv
`timescale 1ns/1ps
module test_dac_serial_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic        ldac_n = 1'b0, clr_n = 1'b1, rstin_n = 1'b1, twos_comp = 1'b0;
    logic        sdo, clamp_active;
    logic [63:0] dac_codes;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] in_m [4];
    logic [15:0] out_m [4];
    logic [23:0] sdo_cap;

    typedef struct {
        int          kind;   // 0 codes, 1 clamp flag, 2 sdo word, 3 sdo bit
        string       req;
        logic [63:0] exp;
    } item_t;
    item_t q[$];
    event chk_ev;

    always #10 clk = ~clk;

    dac_serial_front i_dac_serial_front (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n), .rstin_n(rstin_n), .twos_comp(twos_comp),
        .sdo(sdo), .dac_codes(dac_codes), .clamp_active(clamp_active)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        item_t it;
        logic [63:0] act;
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                it = q.pop_front();
                case (it.kind)
                    0:       act = dac_codes;
                    1:       act = {63'd0, clamp_active};
                    2:       act = {40'd0, sdo_cap};
                    default: act = {63'd0, sdo};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic [63:0] pack_out();
        return {out_m[3], out_m[2], out_m[1], out_m[0]};
    endfunction

    task automatic push(input int kind, input string req, input logic [63:0] exp);
        item_t it;
        it.kind = kind; it.req = req; it.exp = exp;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    function automatic logic [31:0] wr_word(input logic [1:0] ch, input logic [15:0] d);
        return {8'd0, 1'b0, 3'b010, ch, 2'b00, d};
    endfunction

    task automatic send(input logic [31:0] w, input int n);
        sync_n = 1'b0;
        tick(6);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = w[i];
            sclk = 1'b1;
            tick(6);
            sdo_cap = {sdo_cap[22:0], sdo};
            sclk = 1'b0;
            tick(6);
        end
        sync_n = 1'b1;
        tick(10);
    endtask

    // model of a committed data write
    task automatic model_write(input int ch, input logic [15:0] d);
        in_m[ch] = d;
        if (!ldac_n) out_m[ch] = d;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin in_m[c] = '0; out_m[c] = '0; end
        sdo_cap = '0;
        tick(4);
        rst_n = 1'b1;
        tick(6);
        // R10 reset state
        push(0, "R10 codes", 64'd0);
        push(1, "R10 clamp flag", 64'd0);
        push(3, "R10 sdo", 64'd0);

        // R1 R4: writes with ldac low
        send(wr_word(2'd1, 16'h1234), 24); model_write(1, 16'h1234);
        push(0, "R4 write ch1", pack_out());
        send(wr_word(2'd3, 16'hABCD), 24); model_write(3, 16'hABCD);
        send(wr_word(2'd0, 16'h0001), 24); model_write(0, 16'h0001);
        push(0, "R1 write ch3 and ch0", pack_out());

        // R2: wrong bit counts
        send({1'b0, wr_word(2'd2, 16'h4444)} >> 1, 23);
        push(0, "R2 23-bit frame dropped", pack_out());
        send({8'd0, wr_word(2'd2, 16'h4545)}, 25);
        push(0, "R2 25-bit frame dropped", pack_out());

        // R3: not a data write
        send({8'd0, 1'b1, 3'b010, 2'd2, 2'b00, 16'h6666}, 24);
        push(0, "R3 read frame ignored", pack_out());
        send({8'd0, 1'b0, 3'b011, 2'd2, 2'b00, 16'h6767}, 24);
        push(0, "R3 other select ignored", pack_out());
        send({8'd0, 1'b0, 3'b010, 2'd2, 2'b01, 16'h6868}, 24);
        push(0, "R3 reserved bits set ignored", pack_out());

        // R5: ldac high, inputs only
        ldac_n = 1'b1;
        tick(6);
        send(wr_word(2'd2, 16'h5555), 24); model_write(2, 16'h5555);
        send(wr_word(2'd0, 16'h7777), 24); model_write(0, 16'h7777);
        push(0, "R5 outputs held", pack_out());
        // R6: ldac fall copies all
        ldac_n = 1'b0;
        for (int c = 0; c < 4; c++) out_m[c] = in_m[c];
        tick(8);
        push(0, "R6 ldac fall copies all", pack_out());

        // R7: clear edge
        clr_n = 1'b0;
        for (int c = 0; c < 4; c++) begin in_m[c] = '0; out_m[c] = '0; end
        tick(8);
        push(0, "R7 clear zeroes", pack_out());
        send(wr_word(2'd1, 16'h2222), 24); model_write(1, 16'h2222);
        push(0, "R7 write during held clear", pack_out());
        clr_n = 1'b1;
        tick(6);
        ldac_n = 1'b1; tick(6);
        ldac_n = 1'b0;
        for (int c = 0; c < 4; c++) out_m[c] = in_m[c];
        tick(8);
        push(0, "R7 input registers were cleared", pack_out());

        // R8: clamp in both codings
        send(wr_word(2'd3, 16'h0F0F), 24); model_write(3, 16'h0F0F);
        rstin_n = 1'b0;
        tick(8);
        push(0, "R8 clamp offset binary", {4{16'h8000}});
        push(1, "R8 clamp flag", 64'd1);
        twos_comp = 1'b1;
        tick(2);
        push(0, "R8 clamp twos complement", 64'd0);
        twos_comp = 1'b0;
        rstin_n = 1'b1;
        tick(8);
        push(0, "R8 values restored", pack_out());
        push(1, "R8 flag released", 64'd0);

        // R9: chain delay
        send({8'd0, 24'hD5C396}, 24);
        sdo_cap = '0;
        send({8'd0, 24'hA00000}, 24);
        push(2, "R9 sdo 24-bit delay", {40'd0, 24'hD5C396});
        push(0, "R9 chain frames leave registers", pack_out());

        tick(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule